// File: doc/BRIEF.md
# Decoy Read Cycle Inserter for a Byte-Wide Memory Bus

This block sits between a processor core and an external byte-wide RAM. It owns the external address and strobe pins. It runs every external access as a bus cycle of fixed shape: one clock with the address latch strobe high, then two clocks with the read or write strobe low. While the core signals that a program is running and has no access of its own waiting, the block fills every free bus slot with a read of its own. These decoy reads go to addresses taken from a 16-bit linear feedback shift register. A probe on the pins therefore sees a continuous stream of reads, and cannot tell where the program's real fetches and data reads are.

Decoy reads drive the pins exactly as real reads do. The byte that comes back from a decoy read is discarded. The byte that comes back from a real read is handed to the core with a one-clock valid pulse. Writes are only ever issued on behalf of the core.

The core offers an access with a valid/ready handshake. The block accepts it only at a cycle boundary, and a waiting core access always wins over a further decoy. The register sequence can be reseeded from a free-running source. An internal flag marks decoy cycles, so that they can be observed on chip.

Top module: `bus_decoy_seq`

## Requirements
- R1: While reset is asserted, `ext_ale` and `ext_oe` are low, `ext_rd_n` and `ext_wr_n` are high, and `decoy_cycle`, `core_ready` and `core_rvalid` are low.
- R2: Every bus cycle is exactly one clock of `ext_ale` high with both strobes high, followed by exactly two clocks with one strobe low: `ext_rd_n` for reads, `ext_wr_n` for writes. `ext_addr` holds one value across all three clocks. For writes, `ext_oe` is high and `ext_wdata` carries the core's byte during the strobe clocks.
- R3: If `run` is high in the last clock of a cycle, the next cycle's `ext_ale` follows in the very next clock, with no idle clock between the two.
- R4: A decoy cycle is always a read: `ext_wr_n` stays high and `ext_oe` stays low throughout it.
- R5: Decoy addresses are successive states of a Galois shift register. One step is `s' = (s >> 1) ^ (s[0] ? 16'hB400 : 0)`. After reset the state is `16'hACE1`. The first decoy uses the current state, and the state takes one step per decoy cycle and at no other time.
- R6: A one-clock `seed_load` with a nonzero `seed_val` replaces the state, so the next decoy address is `seed_val`. A `seed_load` with a zero `seed_val` leaves the sequence unchanged.
- R7: `core_ready` is asserted only while the bus is idle or in the last strobe clock of a cycle, and only while `core_req` is high. The accepted access is the next cycle on the bus, with the core's address. A request raised during a decoy waits for that decoy to finish, and then starts ahead of any further decoy.
- R8: After a real read, `core_rvalid` is high for exactly the clock that follows the last strobe clock. In that clock `core_rdata` holds the `ext_rdata` byte sampled at the end of the last strobe clock.
- R9: After a decoy read, `core_rvalid` stays low and `core_rdata` keeps the byte from the last real read.
- R10: With `run` low and no request, the bus goes idle once the current cycle completes. Core requests are still served while `run` is low.
- R11: `decoy_cycle` is high in all three clocks of a decoy cycle and low in every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Program executing; enables decoy filling |
| seed_load | input | 1 | Load `seed_val` into the address sequence state |
| seed_val | input | 16 | Free-running seed value |
| core_req | input | 1 | Core access valid |
| core_we | input | 1 | Core access is a write |
| core_addr | input | 16 | Core access address |
| core_wdata | input | 8 | Core write byte |
| core_ready | output | 1 | Core access accepted this clock |
| core_rdata | output | 8 | Byte from the last real read |
| core_rvalid | output | 1 | `core_rdata` updated by a real read |
| ext_addr | output | 16 | External address |
| ext_ale | output | 1 | Address phase strobe |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_wdata | output | 8 | Byte driven during writes |
| ext_oe | output | 1 | Enable for the data bus drivers |
| ext_rdata | input | 8 | Byte returned by the RAM |
| decoy_cycle | output | 1 | Current cycle is a decoy |

## Verification
At a cycle boundary, two functions can compete in the same clock: starting a real core access, and starting the next decoy (which also steps the address sequence). The bench runs a continuous decoy stream and raises core requests after delays of zero to five clocks. This places requests in the address clock, in either strobe clock, and exactly at the boundary of a decoy. A collision is judged correct if three things hold: the next `ext_ale` carries the core's address without a gap; `core_ready` appeared only in a boundary clock; and the following decoy continues the bench's own model of the register sequence with no skipped step.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  // Bus cycle phase: one address clock, then two strobe clocks.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_XFER1 = 2'd2,
    PH_XFER2 = 2'd3
  } phase_e;

  // Origin and direction of the cycle currently on the bus.
  typedef enum logic [1:0] {
    KIND_DECOY = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } kind_e;

endpackage

// File: rtl/bdc_lfsr.sv
// Galois shift register that supplies decoy addresses (R5, R6).
module bdc_lfsr #(
  parameter int          LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  output logic [LW-1:0] state
);

  logic [LW-1:0] state_q;
  logic [LW-1:0] state_d;
  logic [LW-1:0] stepped;
  logic          en;

  always_comb begin
    stepped = {1'b0, state_q[LW-1:1]} ^ (state_q[0] ? TAPS : '0);
    en      = 1'b0;
    state_d = state_q;
    if (load && (|load_val)) begin
      en      = 1'b1;
      state_d = load_val;
    end else if (adv) begin
      en      = 1'b1;
      state_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (en) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/bdc_seq.sv
// Bus cycle sequencer: picks real or decoy at each boundary (R2, R3, R7, R10).
module bdc_seq
  import bdc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  input  logic [AW-1:0] decoy_addr,
  output logic          decoy_adv,
  output logic          core_ready,
  output phase_e        phase,
  output kind_e         kind,
  output logic [AW-1:0] cyc_addr,
  output logic [DW-1:0] cyc_wdata
);

  phase_e        phase_q, phase_d;
  kind_e         kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          at_edge;
  logic          take_real;
  logic          take_decoy;
  logic          load_cyc;

  always_comb begin
    at_edge    = (phase_q == PH_IDLE) || (phase_q == PH_XFER2);
    take_real  = at_edge && core_req;
    take_decoy = at_edge && !core_req && run;
    load_cyc   = take_real || take_decoy;

    unique case (phase_q)
      PH_ADDR:  phase_d = PH_XFER1;
      PH_XFER1: phase_d = PH_XFER2;
      default:  phase_d = load_cyc ? PH_ADDR : PH_IDLE;
    endcase

    if (take_real) begin
      kind_d  = core_we ? KIND_WRITE : KIND_READ;
      addr_d  = core_addr;
      wdata_d = core_we ? core_wdata : '0;
    end else begin
      kind_d  = KIND_DECOY;
      addr_d  = decoy_addr;
      wdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_DECOY;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_cyc) begin
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign decoy_adv  = take_decoy;
  assign core_ready = take_real;
  assign phase      = phase_q;
  assign kind       = kind_q;
  assign cyc_addr   = addr_q;
  assign cyc_wdata  = wdata_q;

endmodule

// File: rtl/bdc_ret.sv
// Read return path: forwards real read bytes, drops decoy bytes (R8, R9).
module bdc_ret
  import bdc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  kind_e         kind,
  input  logic [DW-1:0] ext_rdata,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid
);

  logic [DW-1:0] rdata_q;
  logic          valid_q;
  logic          capture;

  always_comb begin
    capture = (phase == PH_XFER2) && (kind == KIND_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= ext_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
    end
  end

  assign core_rdata  = rdata_q;
  assign core_rvalid = valid_q;

endmodule

// File: rtl/bus_decoy_seq.sv
// Top: decoy read cycle inserter on a byte-wide external memory bus.
module bus_decoy_seq
  import bdc_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int          DW   = 8,
  parameter int          LW   = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter logic [LW-1:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          seed_load,
  input  logic [LW-1:0] seed_val,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ready,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid,
  output logic [AW-1:0] ext_addr,
  output logic          ext_ale,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  output logic [DW-1:0] ext_wdata,
  output logic          ext_oe,
  input  logic [DW-1:0] ext_rdata,
  output logic          decoy_cycle
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   req_g;
  logic                   run_g;
  logic                   decoy_adv;
  logic [LW-1:0]          lfsr_state;
  phase_e                 phase;
  kind_e                  kind;
  logic [AW-1:0]          cyc_addr;
  logic [DW-1:0]          cyc_wdata;
  logic                   in_xfer;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign req_g = core_req && rst_int_n;
  assign run_g = run && rst_int_n;

  bdc_lfsr #(
    .LW   (LW),
    .TAPS (TAPS),
    .SEED (SEED)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (decoy_adv),
    .load     (seed_load),
    .load_val (seed_val),
    .state    (lfsr_state)
  );

  bdc_seq #(
    .AW (AW),
    .DW (DW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (run_g),
    .core_req   (req_g),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .decoy_addr (lfsr_state[AW-1:0]),
    .decoy_adv  (decoy_adv),
    .core_ready (core_ready),
    .phase      (phase),
    .kind       (kind),
    .cyc_addr   (cyc_addr),
    .cyc_wdata  (cyc_wdata)
  );

  bdc_ret #(
    .DW (DW)
  ) u_ret (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .phase       (phase),
    .kind        (kind),
    .ext_rdata   (ext_rdata),
    .core_rdata  (core_rdata),
    .core_rvalid (core_rvalid)
  );

  // Pin decode from the registered phase and kind: identical shape for
  // real and decoy reads.
  always_comb begin
    in_xfer     = (phase == PH_XFER1) || (phase == PH_XFER2);
    ext_ale     = (phase == PH_ADDR);
    ext_rd_n    = !(in_xfer && (kind != KIND_WRITE));
    ext_wr_n    = !(in_xfer && (kind == KIND_WRITE));
    ext_oe      = in_xfer && (kind == KIND_WRITE);
    ext_addr    = cyc_addr;
    ext_wdata   = cyc_wdata;
    decoy_cycle = (phase != PH_IDLE) && (kind == KIND_DECOY);
  end

endmodule

// File: rtl/bus_decoy_seq_chk.sv
// Protocol checker for bus_decoy_seq.
module bus_decoy_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          core_ready,
  input logic          core_rvalid,
  input logic [AW-1:0] ext_addr,
  input logic          ext_ale,
  input logic          ext_rd_n,
  input logic          ext_wr_n,
  input logic          ext_oe,
  input logic          decoy_cycle
);

  logic strobe;
  assign strobe = !ext_rd_n || !ext_wr_n;

  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |=> strobe && !ext_ale); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n) && !(ext_ale && strobe)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $stable(ext_addr)); // R2
  AST_NO_GAP_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && run) |=> ext_ale); // R3
  AST_DECOY_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    decoy_cycle |-> ext_wr_n && !ext_oe); // R4
  AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> !ext_ale && !$past(ext_ale)); // R7
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    core_rvalid |-> $past(!ext_rd_n && !decoy_cycle)); // R8
  AST_DECOY_FLAG_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (decoy_cycle && !ext_ale) |-> $past(decoy_cycle)); // R11

endmodule

bind bus_decoy_seq bus_decoy_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .core_ready  (core_ready),
  .core_rvalid (core_rvalid),
  .ext_addr    (ext_addr),
  .ext_ale     (ext_ale),
  .ext_rd_n    (ext_rd_n),
  .ext_wr_n    (ext_wr_n),
  .ext_oe      (ext_oe),
  .decoy_cycle (decoy_cycle)
);

// File: tb/bus_decoy_seq_test.sv
module bus_decoy_seq_test;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic        seed_load;
  logic [15:0] seed_val;
  logic        core_req;
  logic        core_we;
  logic [15:0] core_addr;
  logic [7:0]  core_wdata;
  logic        core_ready;
  logic [7:0]  core_rdata;
  logic        core_rvalid;
  logic [15:0] ext_addr;
  logic        ext_ale;
  logic        ext_rd_n;
  logic        ext_wr_n;
  logic [7:0]  ext_wdata;
  logic        ext_oe;
  logic [7:0]  ext_rdata;
  logic        decoy_cycle;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench-side models.
  logic [15:0] exp_lfsr;
  bit          pend;
  logic [15:0] pend_addr;
  bit          pend_we;
  logic [7:0]  pend_wdata;
  int          mph;
  int          m_kind;     // 0 decoy, 1 read, 2 write
  logic [15:0] m_addr;
  logic [7:0]  m_wdata;
  logic [7:0]  last_rd;
  bit          end_run;
  bit          end_req;
  logic        strobe;

  bus_decoy_seq uut (
    .clk(clk), .rst_n(rst_n), .run(run), .seed_load(seed_load), .seed_val(seed_val),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_rdata(core_rdata), .core_rvalid(core_rvalid),
    .ext_addr(ext_addr), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_wdata(ext_wdata), .ext_oe(ext_oe), .ext_rdata(ext_rdata), .decoy_cycle(decoy_cycle)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] ram_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  assign ext_rdata = ram_byte(ext_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Bus monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      strobe = !ext_rd_n || !ext_wr_n;
      if (mph == 3) begin
        if (m_kind == 1) begin
          chk(core_rvalid == 1'b1, "R8 rvalid", {31'd0, core_rvalid}, 1);
          chk(core_rdata == ram_byte(m_addr), "R8 rdata", {24'd0, core_rdata}, {24'd0, ram_byte(m_addr)});
          last_rd = ram_byte(m_addr);
        end else if (m_kind == 0) begin
          chk(core_rvalid == 1'b0, "R9 rvalid", {31'd0, core_rvalid}, 0);
          chk(core_rdata == last_rd, "R9 rdata", {24'd0, core_rdata}, {24'd0, last_rd});
        end
        chk(ext_ale == (end_run || end_req), "R3 R10 next cycle", {31'd0, ext_ale}, {31'd0, end_run || end_req});
      end
      if (mph == 0 || mph == 3) begin
        if (ext_ale) begin
          m_addr = ext_addr;
          chk(!strobe, "R2 ale alone", {31'd0, strobe}, 0);
          if (pend) begin
            m_kind  = pend_we ? 2 : 1;
            m_wdata = pend_wdata;
            chk(ext_addr == pend_addr, "R7 real addr", {16'd0, ext_addr}, {16'd0, pend_addr});
            chk(decoy_cycle == 1'b0, "R11 real flag", {31'd0, decoy_cycle}, 0);
            pend = 0;
          end else begin
            m_kind = 0;
            chk(ext_addr == exp_lfsr, "R5 decoy addr", {16'd0, ext_addr}, {16'd0, exp_lfsr});
            chk(decoy_cycle == 1'b1, "R11 decoy flag", {31'd0, decoy_cycle}, 1);
            exp_lfsr = lfsr_next(exp_lfsr);
          end
          mph = 1;
        end else begin
          chk(!strobe, "R2 idle strobe", {31'd0, strobe}, 0);
          chk(decoy_cycle == 1'b0, "R11 idle flag", {31'd0, decoy_cycle}, 0);
          mph = 0;
        end
      end else begin
        chk(!ext_ale, "R2 ale in strobe", {31'd0, ext_ale}, 0);
        if (m_kind == 2) begin
          chk(!ext_wr_n && ext_rd_n && ext_oe, "R2 write strobe",
              {29'd0, ext_wr_n, ext_rd_n, ext_oe}, 32'b011);
          chk(ext_wdata == m_wdata, "R2 write data", {24'd0, ext_wdata}, {24'd0, m_wdata});
        end else begin
          chk(!ext_rd_n && ext_wr_n && !ext_oe, "R2 R4 read strobe",
              {29'd0, ext_rd_n, ext_wr_n, ext_oe}, 32'b010);
        end
        chk(ext_addr == m_addr, "R2 addr hold", {16'd0, ext_addr}, {16'd0, m_addr});
        chk(decoy_cycle == (m_kind == 0), "R11 flag span", {31'd0, decoy_cycle}, {31'd0, m_kind == 0});
        if (mph == 2) begin
          end_run = run;
          end_req = core_req && core_ready;
          mph = 3;
        end else begin
          mph = 2;
        end
      end
      if (core_ready && !(mph == 3 || (mph == 0 && !ext_ale)))
        chk(1'b0, "R7 ready off boundary", mph, 3);
    end
  end

  task automatic do_req(input bit we, input logic [15:0] a, input logic [7:0] d, input int dly);
    repeat (dly) @(posedge clk);
    @(posedge clk); #2;
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    forever begin
      @(negedge clk);
      if (core_ready) break;
    end
    pend = 1; pend_addr = a; pend_we = we; pend_wdata = d;
    @(posedge clk); #2;
    core_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "R7 watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; run = 0; seed_load = 0; seed_val = '0;
    core_req = 0; core_we = 0; core_addr = '0; core_wdata = '0;
    exp_lfsr = 16'hACE1; pend = 0; mph = 0; m_kind = 0; m_addr = '0; m_wdata = '0;
    last_rd = '0; end_run = 0; end_req = 0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ext_ale && !ext_oe && ext_rd_n && ext_wr_n, "R1 bus pins",
        {28'd0, ext_ale, ext_oe, ext_rd_n, ext_wr_n}, 32'b0011);
    chk(!decoy_cycle && !core_ready && !core_rvalid, "R1 core side",
        {29'd0, decoy_cycle, core_ready, core_rvalid}, 0);
    @(posedge clk); #2 rst_n = 1;
    repeat (4) @(posedge clk);

    // Continuous decoy stream (R3, R4, R5, R11)
    #2 run = 1;
    repeat (90) @(posedge clk);

    // Reads and writes at staggered offsets into the stream (R7, R8, R9)
    for (int i = 0; i < 16; i++)
      do_req(1'b0, 16'h1111 * i[15:0] ^ 16'h0F0F, 8'h00, i % 6);
    for (int i = 0; i < 8; i++)
      do_req(1'b1, 16'h8000 + 16'(i * 37), 8'hA0 + i[7:0], (i * 5) % 6);
    for (int i = 0; i < 6; i++)
      do_req(1'b0, 16'h4000 + i[15:0], 8'h00, 0);
    repeat (20) @(posedge clk);

    // run low: bus settles idle, real requests still served (R10)
    #2 run = 0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(!ext_ale && ext_rd_n && ext_wr_n && !decoy_cycle, "R10 idle",
        {28'd0, ext_ale, ext_rd_n, ext_wr_n, decoy_cycle}, 32'b0110);
    for (int i = 0; i < 4; i++)
      do_req(i[0], 16'hC3C0 + i[15:0], 8'h55 ^ i[7:0], i);
    repeat (12) @(posedge clk);

    // Reseed while idle (R6): nonzero loads, zero is ignored
    @(posedge clk); #2 seed_val = 16'h1234; seed_load = 1;
    @(posedge clk); #2 seed_load = 0; exp_lfsr = 16'h1234;
    @(posedge clk); #2 seed_val = 16'h0000; seed_load = 1;
    @(posedge clk); #2 seed_load = 0; seed_val = 16'hFFFF;
    @(posedge clk); #2 run = 1;
    repeat (45) @(posedge clk);
    #2 run = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(!ext_ale && !decoy_cycle, "R6 R10 settle", {30'd0, ext_ale, decoy_cycle}, 0);

    done = 1;
    finish_run();
  end

endmodule